// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the odd partial remainders of one sector's BCH check into the complete set of 2t syndromes over GF(2^13). For every odd index i it evaluates remainder word (i-1)/2 at alpha^i, where alpha is a root of x^13 + x^4 + x^3 + x + 1 and the codeword length is 8191. Each bit j that is set in the word adds alpha^(i·j mod 8191) into the syndrome. The even syndromes are not evaluated. Each one is taken as the square of an earlier syndrome, S(2k) = S(k)^2.

A start pulse latches the correction capability t, which may be 2, 4, 8, 12 or 24, and clears every syndrome slot. The unit then reads the remainder words through an asynchronous register-file port, spending one cycle per remainder bit. After that it spends one cycle per even syndrome. A one-cycle done strobe marks the end of the run. The syndrome array stays unchanged until the next accepted start. Powers of alpha are produced by a running GF multiplier, not by stored exp/log tables.

Top module: `bch_syn_expand`

## Requirements
- R1: After reset, done is low and every syndrome slot reads zero.
- R2: For odd i = 1, 3, …, 2t−1, S(i) is the XOR of alpha^(i·j mod 8191) over every bit j (0..12) set in remainder word (i−1)/2. Slot k−1 of synFlat, which is bits [13(k−1)+12 : 13(k−1)], holds S(k). Field elements use polynomial basis, with bit n holding the coefficient of alpha^n.
- R3: For k = 1..t, S(2k) equals S(k) squared in GF(2^13).
- R4: When S(k) is zero, S(2k) is zero.
- R5: An accepted start clears all 48 syndrome slots. Slots above 2t read zero when the run ends.
- R6: done is high for exactly one cycle. It rises 14·t clock edges after the edge that samples start.
- R7: A start pulse during a run is ignored. The run keeps its capability, its timing and its results.
- R8: remAddr stays below t, and remData is used in the same cycle that remAddr presents it.
- R9: Syndrome outputs hold their values from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation. Sampled only when idle |
| capIn | input | 5 | Correction capability t (2, 4, 8, 12, 24) |
| remAddr | output | 5 | Index of the remainder word being read |
| remData | input | 13 | Remainder word at remAddr, valid in the same cycle |
| synFlat | output | 624 | Syndromes S(1)..S(48), 13 bits each, S(1) lowest |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions take several things as given. capIn is one of the five legal capabilities whenever start is accepted. The register file returns the word for remAddr within the same cycle. The remainder words do not change while a run is in progress. The bench loads its remainder memory only while the unit is idle and draws capabilities only from the legal set. Its one mid-run start pulse carries a different capability, so the run is shown to ignore it.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;
  localparam int GF_M    = 13;
  localparam logic [GF_M-1:0] GF_POLY = 13'h001B; // x^13 + x^4 + x^3 + x + 1, top term implied
  localparam int T_MAX   = 24;
  localparam int SYN_N   = 2 * T_MAX;
  localparam int IDXW    = $clog2(SYN_N);
  localparam int CAPW    = $clog2(T_MAX + 1);
  localparam int RAW     = $clog2(T_MAX);
  localparam int BITW    = $clog2(GF_M);
  localparam int CNTW    = $clog2(14 * T_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ODD, ST_EVEN} state_t;

  typedef struct packed {
    logic            clearAll;
    logic            oddStep;
    logic            oddAcc;
    logic            nextOdd;
    logic            evenWrite;
    logic [IDXW-1:0] oddSlot;
    logic [IDXW-1:0] evenSlot;
  } ctrl_t;

  function automatic logic [GF_M-1:0] gfMul(input logic [GF_M-1:0] a, input logic [GF_M-1:0] b);
    logic [GF_M-1:0] p;
    p = '0;
    for (int n = GF_M - 1; n >= 0; n--) begin
      p = {p[GF_M-2:0], 1'b0} ^ (p[GF_M-1] ? GF_POLY : '0);
      if (b[n]) p = p ^ a;
    end
    return p;
  endfunction
endpackage

// File: rtl/bch_syn_ctrl.sv
module bch_syn_ctrl
  import bch_syn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CAPW-1:0] capIn,
  input  logic [GF_M-1:0] remData,
  output logic [RAW-1:0]  remAddr,
  output ctrl_t           ctl,
  output logic            done
);
  state_t          state;
  logic [CAPW-1:0] capReg;
  logic [RAW-1:0]  oddK;
  logic [BITW-1:0] bitIdx;
  logic [CAPW-1:0] evenK;
  logic [CNTW-1:0] cycCnt;

  wire idle    = (state == ST_IDLE);
  wire lastBit = (bitIdx == BITW'(GF_M - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      capReg <= '0;
      oddK   <= '0;
      bitIdx <= '0;
      evenK  <= '0;
      done   <= 1'b0;
      cycCnt <= '0;
    end else begin
      done <= (state == ST_EVEN) && (evenK == capReg);
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_ODD;
          capReg <= capIn;
          oddK   <= '0;
          bitIdx <= '0;
          cycCnt <= '0;
        end
        ST_ODD: begin
          cycCnt <= cycCnt + 1'b1;
          if (lastBit) begin
            bitIdx <= '0;
            if (CAPW'(oddK) == capReg - 1'b1) begin
              state <= ST_EVEN;
              evenK <= CAPW'(1);
            end else begin
              oddK <= oddK + 1'b1;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_EVEN: begin
          cycCnt <= cycCnt + 1'b1;
          if (evenK == capReg) state <= ST_IDLE;
          else evenK <= evenK + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign remAddr = oddK;

  always_comb begin
    ctl           = '0;
    ctl.clearAll  = idle && start;
    ctl.oddStep   = (state == ST_ODD);
    ctl.oddAcc    = (state == ST_ODD) && remData[bitIdx];
    ctl.nextOdd   = (state == ST_ODD) && lastBit;
    ctl.evenWrite = (state == ST_EVEN);
    ctl.oddSlot   = {IDXW'(oddK)} << 1;
    ctl.evenSlot  = IDXW'(evenK - 1'b1);
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycCnt == CNTW'(capReg) * CNTW'(14)));
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && start && !(state == ST_EVEN && evenK == capReg)) |=> (cycCnt == $past(cycCnt) + 1'b1));
  assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ODD) |-> (CAPW'(remAddr) < capReg));
endmodule

// File: rtl/bch_syn_dpath.sv
module bch_syn_dpath
  import bch_syn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_t                 ctl,
  output logic [SYN_N*GF_M-1:0] synFlat
);
  localparam logic [GF_M-1:0] ONE    = GF_M'(1);
  localparam logic [GF_M-1:0] ALPHA  = GF_M'(2);
  localparam logic [GF_M-1:0] ALPHA2 = GF_M'(4);

  logic [GF_M-1:0] syn [SYN_N];
  logic [GF_M-1:0] basePow;
  logic [GF_M-1:0] runPow;
  logic [IDXW-1:0] dstSlot;
  logic [GF_M-1:0] srcVal;

  assign dstSlot = {ctl.evenSlot[IDXW-2:0], 1'b1};
  assign srcVal  = syn[ctl.evenSlot];

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clearAll) begin
      for (int s = 0; s < SYN_N; s++) syn[s] <= '0;
      basePow <= ALPHA;
      runPow  <= ONE;
    end else begin
      if (ctl.oddStep) begin
        if (ctl.oddAcc) syn[ctl.oddSlot] <= syn[ctl.oddSlot] ^ runPow;
        if (ctl.nextOdd) begin
          runPow  <= ONE;
          basePow <= gfMul(basePow, ALPHA2);
        end else begin
          runPow <= gfMul(runPow, basePow);
        end
      end
      if (ctl.evenWrite) syn[dstSlot] <= gfMul(srcVal, srcVal);
    end
  end

  for (genvar g = 0; g < SYN_N; g++) begin : g_flat
    assign synFlat[g*GF_M +: GF_M] = syn[g];
  end

  // Powers of a primitive element are never zero (R2)
  assert_powers_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (runPow != '0) && (basePow != '0));
  // Squaring preserves zero (R4)
  assert_zero_square_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.evenWrite && srcVal == '0) |=> (syn[$past(dstSlot)] == '0));
endmodule

// File: rtl/bch_syn_expand.sv
module bch_syn_expand
  import bch_syn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CAPW-1:0]       capIn,
  output logic [RAW-1:0]        remAddr,
  input  logic [GF_M-1:0]       remData,
  output logic [SYN_N*GF_M-1:0] synFlat,
  output logic                  done
);
  ctrl_t ctl;

  bch_syn_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .capIn(capIn),
    .remData(remData), .remAddr(remAddr), .ctl(ctl), .done(done)
  );

  bch_syn_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .synFlat(synFlat)
  );

  assert_hold_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(synFlat));
endmodule

// File: tb/tb_bch_syn_expand.sv
module tb_bch_syn_expand;
  localparam int M = 13;
  localparam int NS = 48;
  localparam int NMAX = 8191;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [4:0] capIn = 0;
  logic [4:0] remAddr;
  logic [M-1:0] remData;
  logic [NS*M-1:0] synFlat;
  logic done;

  logic [M-1:0] remMem [24];
  int expS [NS+1];
  int nChecks = 0;
  int nFails = 0;
  int lcg = 12345;

  always #2.5 clk = ~clk;

  assign remData = (remAddr < 5'd24) ? remMem[remAddr] : '0;

  bch_syn_expand dut (
    .clk(clk), .rst_n(rst_n), .start(start), .capIn(capIn),
    .remAddr(remAddr), .remData(remData), .synFlat(synFlat), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int xtime(input int v);
    int r;
    r = (v << 1) & 16'h1FFF;
    if (v & 16'h1000) r = r ^ 16'h001B;
    return r;
  endfunction

  function automatic int alphaPow(input int e);
    int v = 1;
    for (int n = 0; n < e % NMAX; n++) v = xtime(v);
    return v;
  endfunction

  function automatic int logOf(input int v);
    int p = 1;
    for (int n = 0; n < NMAX; n++) begin
      if (p == v) return n;
      p = xtime(p);
    end
    return -1;
  endfunction

  function automatic int synAt(input int k);
    return int'(synFlat[(k-1)*M +: M]);
  endfunction

  task automatic buildExpected(input int t);
    for (int k = 0; k <= NS; k++) expS[k] = 0;
    for (int i = 1; i < 2*t; i += 2) begin
      for (int j = 0; j < M; j++)
        if (remMem[(i-1)/2][j]) expS[i] = expS[i] ^ alphaPow((i*j) % NMAX);
    end
    for (int k = 1; k <= t; k++)
      expS[2*k] = (expS[k] == 0) ? 0 : alphaPow((2 * logOf(expS[k])) % NMAX);
  endtask

  // Run one computation; injectAt > 0 pulses a stray start mid-run (R7)
  task automatic runCase(input string name, input int t, input int injectAt);
    int n;
    buildExpected(t);
    @(negedge clk); start = 1; capIn = 5'(t);
    @(negedge clk); start = 0; capIn = 5'd2;
    n = 0;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      start = 0;
      if (done) break;
      if (injectAt > 0 && n == injectAt) begin
        start = 1;
        capIn = 5'd2;
        remMem[0] = remMem[0];
      end
    end
    start = 0;
    chk(n == 14*t, $sformatf("R6/R7 latency %s", name), n, 14*t);
    for (int k = 1; k <= NS; k++) begin
      if (k <= 2*t && k % 2 == 1)
        chk(synAt(k) == expS[k], $sformatf("R2 %s S(%0d)", name, k), synAt(k), expS[k]);
      else if (k <= 2*t)
        chk(synAt(k) == expS[k], $sformatf("R3/R4 %s S(%0d)", name, k), synAt(k), expS[k]);
      else
        chk(synAt(k) == 0, $sformatf("R5 %s S(%0d)", name, k), synAt(k), 0);
    end
    @(negedge clk);
    chk(done == 0, $sformatf("R6 pulse width %s", name), done, 0);
    repeat (3) @(negedge clk);
    chk(synAt(1) == expS[1] && synAt(2*t) == expS[2*t], $sformatf("R9 hold %s", name),
        synAt(2*t), expS[2*t]);
  endtask

  task automatic fillRand();
    for (int w = 0; w < 24; w++) begin
      lcg = lcg * 1103515245 + 12345;
      remMem[w] = M'(lcg >>> 11);
    end
  endtask

  task automatic testReset();
    chk(done == 0, "R1 done at reset", done, 0);
    chk(synFlat == '0, "R1 syndromes at reset", 0, 0);
  endtask

  task automatic testAllZero();
    for (int w = 0; w < 24; w++) remMem[w] = '0;
    runCase("zero t2", 2, 0);
  endtask

  task automatic testUnitBits();
    for (int w = 0; w < 24; w++) remMem[w] = 13'h0001;
    runCase("unit t8", 8, 0);
  endtask

  task automatic testPartialZero();
    fillRand();
    remMem[0] = '0;
    runCase("S1zero t4", 4, 0);
  endtask

  task automatic testCaps();
    fillRand(); runCase("rand t12", 12, 0);
    fillRand(); runCase("rand t24", 24, 0);
    remMem[3] = 13'h1FFF; runCase("full t8", 8, 0);
  endtask

  task automatic testBusyStart();
    fillRand();
    runCase("busy t24", 24, 50);
  endtask

  task automatic testShrink();
    fillRand(); runCase("big t24", 24, 0);
    fillRand(); runCase("small t2", 2, 0);
  endtask

  initial begin
    for (int w = 0; w < 24; w++) remMem[w] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    testAllZero();
    testUnitBits();
    testPartialZero();
    testCaps();
    testBusyStart();
    testShrink();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule